// File: doc/BRIEF.md
# Four-Bit Add/Subtract/Multiply Calculator

This block is a purely combinational arithmetic unit for two small unsigned operands. A two-bit operation code picks addition, subtraction or multiplication. The answer comes back on one 8-bit result bus, and two status flags from the add/subtract path sit beside it.

Inside there are three parts. The first is a ripple adder/subtractor that uses full-adder cells and inverts the second operand for subtraction. The second is a carry-save array multiplier that returns the full double-width product. The third is an 8-bit two-input multiplexer. The upper bit of the operation code drives the multiplexer. The lower bit tells the adder/subtractor whether to add or subtract, whatever operation is selected. The narrow sum or difference is zero-extended to the result width before it reaches the multiplexer.

Top module: `arith_unit`

## Requirements
- R1: With op_code = 2'b00, result[3:0] equals (opa + opb) modulo 16.
- R2: With op_code = 2'b01, result[3:0] equals (opa - opb) modulo 16, as a two's-complement difference.
- R3: With op_code[1] = 1, result holds the full 8-bit unsigned product opa * opb.
- R4: When op_code[1] = 1, op_code[0] has no effect on result: codes 2'b10 and 2'b11 give the same product.
- R5: For op_code 2'b00 and 2'b01, result[7:4] is zero.
- R6: carry_flag is the carry out of bit 3 of the adder. When adding, it is bit 4 of opa + opb. When subtracting, it is 1 exactly when opa >= opb, meaning no borrow.
- R7: ovf_flag reports two's-complement overflow. When adding, it is set when both operands have the same sign bit and the sum's bit 3 differs from it. When subtracting, it is set when the operands' sign bits differ and the difference's bit 3 differs from opa[3].
- R8: The flags are produced for every code, multiply included. op_code[0] = 0 gives the add flags and op_code[0] = 1 gives the subtract flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 4 | First operand (X) |
| opb | input | 4 | Second operand (Y) |
| op_code | input | 2 | 00 add, 01 subtract, 1x multiply |
| result | output | 8 | Selected arithmetic result |
| carry_flag | output | 1 | Carry out of the adder/subtractor |
| ovf_flag | output | 1 | Signed overflow of the adder/subtractor |

## Verification
The bench runs all 256 operand pairs under each of the four operation codes and compares the result and both flags against a model built from the requirements.

Each pattern separates a different kind of fault:
- Operand pairs whose sum is 16 or more, or whose difference would borrow, separate the carry and borrow cases.
- Pairs with matching and with opposite sign bits tell a correct overflow term apart from one that ignores the operation.
- Products above 15 catch a dropped upper half or a broken carry chain in the array.
- Codes 10 and 11 are given the same operands, which shows that the low code bit reaches the flags and never the product.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam int unsigned DATA_W = 4;

    typedef enum logic [1:0] {
        OP_ADD     = 2'b00,
        OP_SUB     = 2'b01,
        OP_MUL     = 2'b10,
        OP_MUL_ALT = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic carry;
        logic ovf;
    } add_flags_t;

    function automatic logic is_mul(input op_kind_e op);
        return op[1];
    endfunction

    function automatic logic is_sub(input op_kind_e op);
        return op[0];
    endfunction

endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    assign s  = a ^ b ^ ci;
    assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int unsigned W = calc_pkg::DATA_W
) (
    input  logic                 sub_en,
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    output logic [W-1:0]         sum,
    output calc_pkg::add_flags_t flags
);
    logic [W:0]   chain;
    logic [W-1:0] b_eff;

    assign chain[0] = sub_en;
    assign b_eff    = b ^ {W{sub_en}};

    for (genvar k = 0; k < W; k++) begin : g_bit
        fa_cell u_fa (
            .a  (a[k]),
            .b  (b_eff[k]),
            .ci (chain[k]),
            .s  (sum[k]),
            .co (chain[k+1])
        );
    end

    assign flags.carry = chain[W];
    assign flags.ovf   = chain[W] ^ chain[W-1];
endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
    parameter int unsigned W = calc_pkg::DATA_W
) (
    input  logic [W-1:0]   m,
    input  logic [W-1:0]   q,
    output logic [2*W-1:0] p
);
    localparam int unsigned SW = W + 1;

    logic [W*SW-1:0] s_flat;
    logic [W*W-1:0]  c_flat;
    logic [W-1:0]    rc;

    // row 0: plain partial products, no carries
    for (genvar j = 0; j < W; j++) begin : g_row0
        assign s_flat[j]   = m[j] & q[0];
        assign c_flat[j]   = 1'b0;
    end
    for (genvar i = 0; i < W; i++) begin : g_pad
        assign s_flat[i*SW+W] = 1'b0;
    end

    // carry-save rows: weight i+j gathers pp, shifted sum, previous carry
    for (genvar i = 1; i < W; i++) begin : g_row
        for (genvar j = 0; j < W; j++) begin : g_col
            fa_cell u_fa (
                .a  (m[j] & q[i]),
                .b  (s_flat[(i-1)*SW+j+1]),
                .ci (c_flat[(i-1)*W+j]),
                .s  (s_flat[i*SW+j]),
                .co (c_flat[i*W+j])
            );
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_low
        assign p[i] = s_flat[i*SW];
    end

    // final ripple merge of the last sum and carry vectors
    assign rc[0] = 1'b0;
    for (genvar k = 0; k < W; k++) begin : g_merge
        if (k < W - 1) begin : g_fa
            fa_cell u_fa (
                .a  (s_flat[(W-1)*SW+k+1]),
                .b  (c_flat[(W-1)*W+k]),
                .ci (rc[k]),
                .s  (p[W+k]),
                .co (rc[k+1])
            );
        end else begin : g_top
            assign p[W+k] = s_flat[(W-1)*SW+k+1] ^ c_flat[(W-1)*W+k] ^ rc[k];
        end
    end
endmodule

// File: rtl/word_mux2.sv
module word_mux2 #(
    parameter int unsigned W = 2 * calc_pkg::DATA_W
) (
    input  logic         sel,
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    output logic [W-1:0] out
);
    always_comb begin
        out = sel ? in1 : in0;
    end
endmodule

// File: rtl/arith_unit.sv
module arith_unit #(
    parameter int unsigned W = calc_pkg::DATA_W
) (
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    input  logic [1:0]     op_code,
    output logic [2*W-1:0] result,
    output logic           carry_flag,
    output logic           ovf_flag
);
    import calc_pkg::*;

    localparam int unsigned RW = 2 * W;

    op_kind_e      op;
    logic [W-1:0]  as_sum;
    add_flags_t    as_flags;
    logic [RW-1:0] prod;
    logic [RW-1:0] as_wide;

    assign op = op_kind_e'(op_code);

    addsub_ripple #(.W(W)) u_addsub (
        .sub_en (is_sub(op)),
        .a      (opa),
        .b      (opb),
        .sum    (as_sum),
        .flags  (as_flags)
    );

    csa_array_mult #(.W(W)) u_mult (
        .m (opa),
        .q (opb),
        .p (prod)
    );

    assign as_wide = {{W{1'b0}}, as_sum};

    word_mux2 #(.W(RW)) u_mux (
        .sel (is_mul(op)),
        .in0 (as_wide),
        .in1 (prod),
        .out (result)
    );

    assign carry_flag = as_flags.carry;
    assign ovf_flag   = as_flags.ovf;
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
    parameter int unsigned W = 4
) (
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic [1:0]     op_code,
    input logic [2*W-1:0] result,
    input logic           carry_flag,
    input logic           ovf_flag
);
    logic [W:0]     ref_add;
    logic [W:0]     ref_sub;
    logic [2*W-1:0] ref_mul;

    always_comb begin
        ref_add = {1'b0, opa} + {1'b0, opb};
        ref_sub = {1'b0, opa} - {1'b0, opb};
        ref_mul = {{W{1'b0}}, opa} * {{W{1'b0}}, opb};

        if (op_code == 2'b00)
            a_r1_add_low: assert (result[W-1:0] == ref_add[W-1:0]) else $error("R1 sum");
        if (op_code == 2'b01)
            a_r2_sub_low: assert (result[W-1:0] == ref_sub[W-1:0]) else $error("R2 diff");
        if (op_code[1])
            a_r3_product: assert (result == ref_mul) else $error("R3 product");
        if (!op_code[1])
            a_r5_upper_zero: assert (result[2*W-1:W] == '0) else $error("R5 upper");
        if (op_code[0])
            a_r6_no_borrow: assert (carry_flag == (opa >= opb)) else $error("R6 borrow");
        else
            a_r6_add_carry: assert (carry_flag == ref_add[W]) else $error("R6 carry");
        if (!op_code[0])
            a_r7_add_ovf: assert (ovf_flag == ((opa[W-1] == opb[W-1]) && (ref_add[W-1] != opa[W-1])))
                else $error("R7 add overflow");
        else
            a_r8_sub_ovf: assert (ovf_flag == ((opa[W-1] != opb[W-1]) && (ref_sub[W-1] != opa[W-1])))
                else $error("R8 sub overflow");
    end
endmodule

bind arith_unit arith_unit_chk #(.W(W)) i_chk (
    .opa        (opa),
    .opb        (opb),
    .op_code    (op_code),
    .result     (result),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag)
);

// File: tb/test_arith_unit.sv
module test_arith_unit;

    typedef struct {
        logic [1:0] op;
        logic [3:0] x;
        logic [3:0] y;
        logic [7:0] res;
        logic       c;
        logic       v;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic [1:0] op_code = '0;
    logic [7:0] result;
    logic       carry_flag;
    logic       ovf_flag;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    arith_unit i_arith_unit (
        .opa        (opa),
        .opb        (opb),
        .op_code    (op_code),
        .result     (result),
        .carry_flag (carry_flag),
        .ovf_flag   (ovf_flag)
    );

    function automatic exp_t model(input logic [1:0] op, input logic [3:0] x, input logic [3:0] y);
        exp_t e;
        int   sx;
        int   sy;
        int   ar;
        e.op = op; e.x = x; e.y = y;
        sx = (x >= 8) ? int'(x) - 16 : int'(x);
        sy = (y >= 8) ? int'(y) - 16 : int'(y);
        if (op[0]) begin
            ar  = sx - sy;
            e.c = (x >= y);
        end else begin
            ar  = sx + sy;
            e.c = (int'(x) + int'(y)) > 15;
        end
        e.v = (ar > 7) || (ar < -8);
        if (op[1]) e.res = 8'(int'(x) * int'(y));
        else if (op[0]) e.res = {4'h0, 4'((int'(x) - int'(y)) & 15)};
        else e.res = {4'h0, 4'((int'(x) + int'(y)) & 15)};
        return e;
    endfunction

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [3:0] x, input logic [3:0] y);
        @(posedge clk);
        #1;
        op_code = op; opa = x; opb = y;
        sb_q.push_back(model(op, x, y));
    endtask

    // monitor: compare each item half a period after it was driven
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            string rtag;
            e = sb_q.pop_front();
            case (e.op)
                2'b00:   rtag = "R1/R5 add result";
                2'b01:   rtag = "R2/R5 sub result";
                2'b10:   rtag = "R3 mul result";
                default: rtag = "R4 mul result op_code=11";
            endcase
            check($sformatf("%s x=%0d y=%0d", rtag, e.x, e.y), int'(result), int'(e.res));
            check($sformatf("R6/R8 carry op=%0d x=%0d y=%0d", e.op, e.x, e.y), int'(carry_flag), int'(e.c));
            check($sformatf("R7/R8 ovf op=%0d x=%0d y=%0d", e.op, e.x, e.y), int'(ovf_flag), int'(e.v));
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // reset state: zero operands, add code
        check("R1 reset-state result", int'(result), 0);
        check("R6 reset-state carry", int'(carry_flag), 0);
        check("R7 reset-state ovf", int'(ovf_flag), 0);
        @(posedge clk);
        rst = 1'b0;
        for (int op = 0; op < 4; op++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    drive(2'(op), 4'(x), 4'(y));
        // corner points again: R4 same operands on both multiply codes
        drive(2'b10, 4'hF, 4'hF);
        drive(2'b11, 4'hF, 4'hF);
        drive(2'b01, 4'h8, 4'h1);
        drive(2'b00, 4'h7, 4'h1);
        repeat (3) @(posedge clk);
        check("R3 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule